// File: doc/BRIEF.md
# Sequential Transaction Data Checker

This block is a synthesizable monitor placed beside a request/response handshake that carries at most one transaction at a time. At every rising clock edge it samples the request strobe, the completion strobe, the request data and the returned data. The request data present at the latest request is held in a single capture register. A completion is then judged against two rules: it must not arrive before any request has been seen, and its returned data must match the held copy.

Breaking either rule produces a one-cycle pulse on the matching error output. A sticky flag records that any error has happened, and a saturating counter records how many. The checking rules start afresh each time the synchronous reset is released. They also apply from power-up when reset is never pulsed, because all state starts cleared.

Top module: `seq_txn_monitor`

## Requirements
- R1: On an edge where `start_i` is 1, the value of `data_in_i` on that edge becomes the reference. Later requests replace it, so a completion is always compared against the latest request.
- R2: A completion (`complete_i`=1) on an edge when no request has been sampled since reset pulses `order_err_o` high for the following cycle, and `data_err_o` stays 0.
- R3: A completion after a request, whose `data_out_i` differs from the reference, pulses `data_err_o` high for the following cycle.
- R4: A completion after a request, whose `data_out_i` equals the reference, raises no error output.
- R5: On an edge where `complete_i` is 0, both per-cycle error outputs are 0 in the following cycle, whatever `start_i` and the data inputs do.
- R6: When `start_i` and `complete_i` are both 1 on one edge, the completion is judged against the reference held before that edge. The new `data_in_i` becomes the reference for the next completion.
- R7: While `rst` is 1 on an edge, all outputs are 0 in the following cycle. After reset is released, the rule of R2 applies again until a new request is seen.
- R8: Without any reset pulse, the state starts cleared at power-up, so a completion before the first request is flagged as in R2.
- R9: `err_sticky_o` goes to 1 in the same cycle as the first error pulse and stays 1 until reset.
- R10: `err_count_o` rises by one in each cycle where an error pulse appears. It holds at its all-ones value (15 with the default 4-bit width) once it gets there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request strobe of the observed handshake |
| complete_i | input | 1 | Completion strobe of the observed handshake |
| data_in_i | input | DATA_W | Request data, captured on a request |
| data_out_i | input | DATA_W | Returned data, compared on a completion |
| order_err_o | output | 1 | One-cycle pulse: completion before any request |
| data_err_o | output | 1 | One-cycle pulse: returned data mismatch |
| err_sticky_o | output | 1 | Set by any error, cleared only by reset |
| err_count_o | output | CNT_W | Saturating count of error pulses |

## Verification
The comparison is driven with matching and mismatching returned data after a single request. This separates a correct comparison from an inverted or missing one. Back-to-back requests followed by a completion carrying the older value show whether the reference really follows the latest request. A combined request-and-completion edge shows whether the comparison uses the old reference while the new data is still captured. Completions before any request, both at power-up with no reset and after each reset release, show that the ordering rule is re-armed. A long run of errors drives the counter to its ceiling and checks that it stops there.

// File: rtl/seq_mon_pkg.sv
package seq_mon_pkg;

    // Per-cycle verdict of one sampled edge
    typedef struct packed {
        logic order;   // completion with no request seen
        logic data;    // returned data differs from reference
    } err_flags_t;

    localparam err_flags_t NO_ERR = '{order: 1'b0, data: 1'b0};

endpackage

// File: rtl/smon_capture.sv
module smon_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_in_i,
    output logic              seen_o,
    output logic [DATA_W-1:0] ref_o
);

    typedef struct packed {
        logic              seen;
        logic [DATA_W-1:0] ref_val;
    } cap_t;

    cap_t cap_d;
    cap_t cap_q = '0;

    always_comb begin
        cap_d = cap_q;
        if (rst) begin
            cap_d = '0;
        end else if (start_i) begin
            cap_d.seen    = 1'b1;
            cap_d.ref_val = data_in_i;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign seen_o = cap_q.seen;
    assign ref_o  = cap_q.ref_val;

    // R1: a request loads the data sampled on the same edge
    p_capture_latest_r1: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (ref_o == $past(data_in_i)));

    // R7: reset clears the request-seen flag
    p_reset_rearm_r7: assert property (@(posedge clk)
        rst |=> !seen_o);

endmodule

// File: rtl/smon_judge.sv
module smon_judge
    import seq_mon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              complete_i,
    input  logic [DATA_W-1:0] data_out_i,
    input  logic              seen_i,
    input  logic [DATA_W-1:0] ref_i,
    output err_flags_t        flags_next_o,
    output err_flags_t        flags_o
);

    err_flags_t flags_d;
    err_flags_t flags_q = NO_ERR;

    always_comb begin
        flags_d = NO_ERR;
        if (!rst && complete_i) begin
            if (!seen_i) begin
                flags_d.order = 1'b1;
            end else if (data_out_i != ref_i) begin
                flags_d.data = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        flags_q <= flags_d;
    end

    assign flags_next_o = flags_d;
    assign flags_o      = flags_q;

    // R2: completion before any request flags an ordering error only
    p_early_complete_r2: assert property (@(posedge clk) disable iff (rst)
        (complete_i && !seen_i) |=> (flags_o.order && !flags_o.data));

    // R3: mismatch on a valid completion flags a data error
    p_mismatch_r3: assert property (@(posedge clk) disable iff (rst)
        (complete_i && seen_i && (data_out_i != ref_i)) |=> flags_o.data);

    // R4: match on a valid completion stays quiet
    p_match_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (complete_i && seen_i && (data_out_i == ref_i)) |=> (flags_o == NO_ERR));

    // R5: no completion, no error
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !complete_i |=> (flags_o == NO_ERR));

    // R7: reset suppresses error pulses
    p_reset_quiet_r7: assert property (@(posedge clk)
        rst |=> (flags_o == NO_ERR));

    // R2/R3: the two errors never pulse together
    p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(flags_o.order && flags_o.data));

endmodule

// File: rtl/smon_tally.sv
module smon_tally
    import seq_mon_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  err_flags_t       flags_next_i,
    output logic             sticky_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             sticky;
        logic [CNT_W-1:0] count;
    } tally_t;

    tally_t tal_d;
    tally_t tal_q = '0;
    logic   hit;

    assign hit = flags_next_i.order | flags_next_i.data;

    always_comb begin
        tal_d = tal_q;
        if (rst) begin
            tal_d = '0;
        end else if (hit) begin
            tal_d.sticky = 1'b1;
            if (tal_q.count != CNT_MAX) begin
                tal_d.count = tal_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        tal_q <= tal_d;
    end

    assign sticky_o = tal_q.sticky;
    assign count_o  = tal_q.count;

    // R9: sticky flag holds until reset
    p_sticky_hold_r9: assert property (@(posedge clk) disable iff (rst)
        sticky_o |=> sticky_o);

    // R10: counter stops at its ceiling
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (count_o == CNT_MAX) |=> (count_o == CNT_MAX));

    // R10: counter steps by one per error below the ceiling
    p_count_step_r10: assert property (@(posedge clk) disable iff (rst)
        (hit && (count_o != CNT_MAX)) |=> (count_o == $past(count_o) + 1'b1));

    // R7: reset clears sticky and count
    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (!sticky_o && (count_o == '0)));

endmodule

// File: rtl/seq_txn_monitor.sv
module seq_txn_monitor
    import seq_mon_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              complete_i,
    input  logic [DATA_W-1:0] data_in_i,
    input  logic [DATA_W-1:0] data_out_i,
    output logic              order_err_o,
    output logic              data_err_o,
    output logic              err_sticky_o,
    output logic [CNT_W-1:0]  err_count_o
);

    logic              seen;
    logic [DATA_W-1:0] ref_val;
    err_flags_t        flags_next;
    err_flags_t        flags;

    smon_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .data_in_i (data_in_i),
        .seen_o    (seen),
        .ref_o     (ref_val)
    );

    smon_judge #(.DATA_W(DATA_W)) u_judge (
        .clk          (clk),
        .rst          (rst),
        .complete_i   (complete_i),
        .data_out_i   (data_out_i),
        .seen_i       (seen),
        .ref_i        (ref_val),
        .flags_next_o (flags_next),
        .flags_o      (flags)
    );

    smon_tally #(.CNT_W(CNT_W)) u_tally (
        .clk          (clk),
        .rst          (rst),
        .flags_next_i (flags_next),
        .sticky_o     (err_sticky_o),
        .count_o      (err_count_o)
    );

    assign order_err_o = flags.order;
    assign data_err_o  = flags.data;

    // R9: any error pulse comes with the sticky flag set
    p_pulse_sets_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (order_err_o || data_err_o) |-> err_sticky_o);

endmodule

// File: tb/seq_txn_monitor_test.sv
module seq_txn_monitor_test;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       start_i = 1'b0;
    logic       complete_i = 1'b0;
    logic [7:0] data_in_i = '0;
    logic [7:0] data_out_i = '0;
    logic       order_err_o;
    logic       data_err_o;
    logic       err_sticky_o;
    logic [3:0] err_count_o;

    int total = 0;
    int bad = 0;
    bit exp_sticky = 1'b0;
    int exp_count = 0;

    always #10 clk = ~clk;   // 50 MHz

    seq_txn_monitor #(.DATA_W(8), .CNT_W(4)) uut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .complete_i   (complete_i),
        .data_in_i    (data_in_i),
        .data_out_i   (data_out_i),
        .order_err_o  (order_err_o),
        .data_err_o   (data_err_o),
        .err_sticky_o (err_sticky_o),
        .err_count_o  (err_count_o)
    );

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One edge of stimulus, then every output checked against the model
    task automatic step(string tag, bit s, bit c, logic [7:0] di, logic [7:0] dq,
                        bit eo, bit ed);
        start_i = s; complete_i = c; data_in_i = di; data_out_i = dq;
        @(posedge clk);
        @(negedge clk);
        if (rst) begin
            exp_sticky = 1'b0;
            exp_count  = 0;
        end else if (eo || ed) begin
            exp_sticky = 1'b1;
            if (exp_count < 15) exp_count++;
        end
        check(tag, "order_err", int'(order_err_o), int'(eo));
        check(tag, "data_err", int'(data_err_o), int'(ed));
        check(tag, "sticky", int'(err_sticky_o), int'(exp_sticky));
        check(tag, "count", int'(err_count_o), exp_count);
    endtask

    task automatic apply_reset(string tag);
        rst = 1'b1;
        // R7: activity during reset is ignored, outputs all zero
        step(tag, 1'b1, 1'b1, 8'hAA, 8'h55, 1'b0, 1'b0);
        step(tag, 1'b0, 1'b1, 8'h00, 8'h01, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_power_up();
        // R8: no reset pulse, completion before any request
        step("R8", 1'b0, 1'b1, 8'h00, 8'h12, 1'b1, 1'b0);
        step("R8", 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_order_after_reset();
        apply_reset("R7");
        step("R2", 1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
        step("R5", 1'b0, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b0);
        step("R2", 1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic t_compare();
        step("R1", 1'b1, 1'b0, 8'h5A, 8'h00, 1'b0, 1'b0);
        step("R4", 1'b0, 1'b1, 8'h00, 8'h5A, 1'b0, 1'b0);
        step("R3", 1'b0, 1'b1, 8'h00, 8'h5B, 1'b0, 1'b1);
        step("R3", 1'b0, 1'b1, 8'h00, 8'hDA, 1'b0, 1'b1);
        step("R5", 1'b1, 1'b0, 8'h5A, 8'h00, 1'b0, 1'b0);
        step("R9", 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_latest_wins();
        step("R1", 1'b1, 1'b0, 8'h33, 8'h00, 1'b0, 1'b0);
        step("R1", 1'b1, 1'b0, 8'h44, 8'h00, 1'b0, 1'b0);
        step("R1", 1'b0, 1'b1, 8'h00, 8'h44, 1'b0, 1'b0);
        step("R1", 1'b0, 1'b1, 8'h00, 8'h33, 1'b0, 1'b1);
    endtask

    task automatic t_same_edge();
        step("R6", 1'b1, 1'b0, 8'h11, 8'h00, 1'b0, 1'b0);
        step("R6", 1'b1, 1'b1, 8'h22, 8'h11, 1'b0, 1'b0);
        step("R6", 1'b0, 1'b1, 8'h00, 8'h22, 1'b0, 1'b0);
        step("R6", 1'b1, 1'b1, 8'h77, 8'h22, 1'b0, 1'b0);
        step("R6", 1'b0, 1'b1, 8'h00, 8'h22, 1'b0, 1'b1);
    endtask

    task automatic t_rearm();
        apply_reset("R7");
        step("R7", 1'b0, 1'b1, 8'h00, 8'h77, 1'b1, 1'b0);
        step("R7", 1'b1, 1'b0, 8'h77, 8'h00, 1'b0, 1'b0);
        step("R7", 1'b0, 1'b1, 8'h00, 8'h77, 1'b0, 1'b0);
    endtask

    task automatic t_saturate();
        apply_reset("R7");
        for (int i = 0; i < 20; i++) begin
            step("R10", 1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
        end
        check("R10", "count at ceiling", int'(err_count_o), 15);
        for (int i = 0; i < 5; i++) begin
            step("R9", 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
        end
        check("R9", "sticky held", int'(err_sticky_o), 1);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        t_power_up();
        t_order_after_reset();
        t_compare();
        t_latest_wins();
        t_same_edge();
        t_rearm();
        t_saturate();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule